// File: doc/BRIEF.md
# Grouped Row Activation Counter Tracker

This block watches the row activations of one DRAM bank and decides when a region of the bank needs an early refresh to protect rows that sit next to heavily opened ones. The bank's rows are cut into a fixed number of equal, contiguous groups. Each group owns one saturating activation counter. The group of an activation is picked by the upper bits of its row address.

When a group collects its threshold-th activation, its counter returns to zero. The block then asks the memory controller to refresh an inclusive row range. The range covers every row of the group, plus the one row just below and the one row just above it, so that rows bordering the group are refreshed as well. At the first and last group this range is clipped to the bank.

Requests are held on the outputs until the controller acknowledges them. Further hits wait in a short queue behind the request on show. A refresh-interval tick clears every counter.

Top module: `row_act_tracker`

## Requirements
- R1: After reset no refresh request is raised and every group counter is zero.
- R2: An activation of row r counts toward group g = r / (ROWS/GROUPS), which is the upper log2(GROUPS) bits of the row address.
- R3: The THRESH-th activation counted in a group since its counter was last zero raises a request on the cycle after that activation is sampled. The counter returns to zero, so the next request for that group needs THRESH further activations.
- R4: For an inner group g with group size S, the request carries first row g*S-1 and last row g*S+S, both inclusive.
- R5: At the bank edges the range is clipped: group 0 starts at row 0, and group GROUPS-1 ends at row ROWS-1.
- R6: A refresh-interval tick clears all group counters, so activations seen before it no longer count.
- R7: An activation sampled in the same cycle as a tick is counted as the first activation of its group in the new interval.
- R8: While the request is raised and not acknowledged, the request and its first and last rows hold still. A request is retired on a clock edge where both the request and the acknowledge are high.
- R9: Pending requests leave in the order of their hits, and up to DEPTH of them, the one on show included, are kept. A hit that finds all DEPTH places taken, with no retirement on that edge, is discarded.
- R10: An acknowledge given while no request is raised has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | A row activation happens this cycle |
| act_row | input | log2(ROWS) | Row address of the activation |
| intv_tick | input | 1 | Start of a new refresh interval; clears the counters |
| ref_req | output | 1 | A refresh range is waiting for the controller (busy) |
| ref_first | output | log2(ROWS) | First row of the range, inclusive |
| ref_last | output | log2(ROWS) | Last row of the range, inclusive |
| ref_ack | input | 1 | Controller takes the current range |

## Verification
A counter that is off by one or updated for the wrong group shows up as a request that comes one activation early or late, or that names a neighbouring range. It appears on the cycle after the activation where the threshold should have been crossed. A counter that survives a tick is exposed within one threshold's worth of activations after the tick. A queue pointer in the wrong state shows as a repeated, missing or reordered range. It appears as soon as the controller drains the queue, and it also shows in how many ranges arrive after a burst of hits with no acknowledge.

// File: rtl/rat_pkg.sv
package rat_pkg;
  // Lowest row of group g for groups of gs rows
  function automatic int unsigned grp_base(int unsigned g, int unsigned gs);
    return g * gs;
  endfunction

  // Inclusive first row of the refresh range, clipped at row 0
  function automatic int unsigned span_first(int unsigned g, int unsigned gs);
    return (g == 0) ? 0 : grp_base(g, gs) - 1;
  endfunction

  // Inclusive last row of the refresh range, clipped at the top row
  function automatic int unsigned span_last(int unsigned g, int unsigned gs,
                                            int unsigned ngrp, int unsigned nrows);
    return (g == ngrp - 1) ? nrows - 1 : grp_base(g, gs) + gs;
  endfunction
endpackage

// File: rtl/rat_counter_bank.sv
module rat_counter_bank #(
  parameter int GROUPS = 16,
  parameter int THRESH = 8,
  localparam int GW = $clog2(GROUPS),
  localparam int CW = (THRESH > 2) ? $clog2(THRESH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_valid,
  input  logic [GW-1:0] act_grp,
  input  logic          intv_tick,
  output logic          hit,
  output logic [GW-1:0] hit_grp
);
  localparam logic [CW-1:0] CNT_TOP = CW'(THRESH - 1);

  logic [CW-1:0] cnt_q [GROUPS];
  logic [GROUPS-1:0] nonzero;

  // hit: this activation is the THRESH-th of its group (never on a tick)
  assign hit     = act_valid && !intv_tick && (cnt_q[act_grp] == CNT_TOP);
  assign hit_grp = act_grp;

  for (genvar g = 0; g < GROUPS; g++) begin : g_cnt
    wire sel = act_valid && (act_grp == GW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)         cnt_q[g] <= '0;
      else if (intv_tick) cnt_q[g] <= sel ? CW'(1) : '0;
      else if (sel)       cnt_q[g] <= (cnt_q[g] == CNT_TOP) ? '0 : cnt_q[g] + CW'(1);
    end
    assign nonzero[g] = (cnt_q[g] != '0);
  end

  // R3: a hit leaves the group's counter at zero
  a_r3_hit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt_q[$past(act_grp)] == '0));

  // R6: a tick without activation leaves all counters at zero
  a_r6_tick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (intv_tick && !act_valid) |=> (nonzero == '0));

  // R7: a tick with activation leaves exactly one counter at one
  a_r7_tick_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (intv_tick && act_valid) |=> ($countones(nonzero) == 1));
endmodule

// File: rtl/rat_req_queue.sv
module rat_req_queue #(
  parameter int DW    = 20,
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          not_empty,
  output logic [DW-1:0] head
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [NW-1:0] fill_q;

  wire full    = (fill_q == NW'(DEPTH));
  wire do_pop  = pop && not_empty;
  wire do_push = push && (!full || do_pop);

  assign not_empty = (fill_q != '0);
  assign head      = mem_q[rd_q];

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      fill_q <= fill_q + NW'(do_push) - NW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data;
  end

  // R9: occupancy never exceeds DEPTH
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= NW'(DEPTH));

  // R10: a pop on an empty queue leaves it empty
  a_r10_idle_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !not_empty && !push) |=> !not_empty);
endmodule

// File: rtl/row_act_tracker.sv
module row_act_tracker #(
  parameter int ROWS   = 1024,
  parameter int GROUPS = 16,
  parameter int THRESH = 8,
  parameter int DEPTH  = 2,
  localparam int RW    = $clog2(ROWS),
  localparam int GW    = $clog2(GROUPS),
  localparam int GSIZE = ROWS / GROUPS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_valid,
  input  logic [RW-1:0] act_row,
  input  logic          intv_tick,
  output logic          ref_req,
  output logic [RW-1:0] ref_first,
  output logic [RW-1:0] ref_last,
  input  logic          ref_ack
);
  import rat_pkg::*;

  logic [GW-1:0] act_grp, hit_grp;
  logic          hit;
  logic [RW-1:0] span_lo, span_hi;

  // R2: group taken from the upper row address bits
  assign act_grp = act_row[RW-1 -: GW];

  rat_counter_bank #(.GROUPS(GROUPS), .THRESH(THRESH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_grp(act_grp),
    .intv_tick(intv_tick), .hit(hit), .hit_grp(hit_grp)
  );

  always_comb begin
    span_lo = RW'(span_first(int'(hit_grp), GSIZE));
    span_hi = RW'(span_last(int'(hit_grp), GSIZE, GROUPS, ROWS));
  end

  rat_req_queue #(.DW(2*RW), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(hit), .push_data({span_lo, span_hi}),
    .pop(ref_ack), .not_empty(ref_req), .head({ref_first, ref_last})
  );

  // R8: an unacknowledged request holds still
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack) |=> (ref_req && $stable(ref_first) && $stable(ref_last)));

  // R3: a hit always leaves a request raised
  a_r3_hit_raises: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ref_req);

  // R4: a range is ordered and spans at least one group
  a_r4_span_order: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (int'(ref_last) - int'(ref_first) >= GSIZE));

  // R1: no request out of reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !ref_req);
endmodule

// File: tb/row_act_tracker_tb_top.sv
`timescale 1ns/1ps
module row_act_tracker_tb_top;
  localparam int ROWS = 1024, GROUPS = 16, THRESH = 8, DEPTH = 2;
  localparam int RW = $clog2(ROWS), GS = ROWS / GROUPS;

  logic clk = 0, rst_n = 0, act_valid = 0, intv_tick = 0, ref_ack = 0;
  logic [RW-1:0] act_row = '0;
  logic ref_req;
  logic [RW-1:0] ref_first, ref_last;

  always #4 clk = ~clk;

  row_act_tracker #(.ROWS(ROWS), .GROUPS(GROUPS), .THRESH(THRESH), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_row(act_row),
    .intv_tick(intv_tick), .ref_req(ref_req), .ref_first(ref_first),
    .ref_last(ref_last), .ref_ack(ref_ack)
  );

  int checks = 0, errors = 0;
  int mcnt [GROUPS];
  int exp_q [$];
  string tag_q [$];
  bit ack_en = 1;
  bit done = 0;

  task automatic check(bit ok, string tag, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  // expected range by the requirements (R4, R5), not by the RTL functions
  function automatic int enc(int g);
    int lo, hi;
    lo = g * GS - 1; hi = g * GS + GS;
    if (lo < 0) lo = 0;
    if (hi > ROWS - 1) hi = ROWS - 1;
    return lo * 65536 + hi;
  endfunction

  task automatic model_act(int row, bit tick, string tag);
    int g;
    g = row / GS;                         // R2
    if (tick) begin                       // R6, R7
      for (int i = 0; i < GROUPS; i++) mcnt[i] = 0;
      mcnt[g] = 1;
    end else begin
      mcnt[g]++;
      if (mcnt[g] == THRESH) begin        // R3
        mcnt[g] = 0;
        if (exp_q.size() < DEPTH) begin   // R9
          exp_q.push_back(enc(g));
          tag_q.push_back(tag);
        end
      end
    end
  endtask

  task automatic act(int row, string tag);
    @(negedge clk);
    act_valid = 1; act_row = RW'(row); intv_tick = 0;
    model_act(row, 0, tag);
  endtask

  task automatic tick(bit with_act, int row);
    @(negedge clk);
    intv_tick = 1; act_valid = with_act; act_row = RW'(row);
    if (with_act) model_act(row, 1, "R7");
    else for (int i = 0; i < GROUPS; i++) mcnt[i] = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      act_valid = 0; intv_tick = 0;
    end
  endtask

  task automatic check_quiet(string tag);
    @(negedge clk);
    act_valid = 0; intv_tick = 0;
    check(ref_req == 0, tag, ref_req, 0);
  endtask

  // monitor: compares the head against the scoreboard and acknowledges
  initial begin
    forever begin
      @(negedge clk);
      if (!done && rst_n && ref_req && ack_en) begin
        if (exp_q.size() == 0) begin
          check(0, "R9 unexpected request", int'(ref_first), -1);
          ref_ack = 1;
        end else begin
          int e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(int'(ref_first) == e / 65536, {t, " first"}, int'(ref_first), e / 65536);
          check(int'(ref_last) == e % 65536, {t, " last"}, int'(ref_last), e % 65536);
          ref_ack = 1;
        end
      end else if (ack_en) ref_ack = 0;
    end
  end

  initial begin
    #(8ns * 100000);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < GROUPS; i++) mcnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_quiet("R1 reset idle");

    // R3, R4: inner group 5 with varied rows
    for (int i = 0; i < THRESH - 1; i++) act(5 * GS + i * 7, "R3");
    check_quiet("R3 no early request");
    act(5 * GS + 63, "R4 group5");
    idle(4);
    // R3: next hit needs THRESH more
    for (int i = 0; i < THRESH - 1; i++) act(5 * GS + i, "R3");
    check_quiet("R3 counter restarted");
    act(5 * GS, "R3 second hit");
    idle(4);

    // R5: edge groups
    for (int i = 0; i < THRESH; i++) act(i, "R5 group0");
    idle(4);
    for (int i = 0; i < THRESH; i++) act(ROWS - 1 - i, "R5 top group");
    idle(4);

    // R6: tick clears counts
    for (int i = 0; i < THRESH - 1; i++) act(3 * GS + 1, "R6");
    tick(0, 0);
    for (int i = 0; i < THRESH - 1; i++) act(3 * GS + 2, "R6");
    check_quiet("R6 no request after tick");
    act(3 * GS + 3, "R6 group3");
    idle(4);

    // R7: tick with activation counts as first
    for (int i = 0; i < THRESH - 2; i++) act(2 * GS, "R7");
    tick(1, 2 * GS + 5);
    for (int i = 0; i < THRESH - 2; i++) act(2 * GS + 9, "R7");
    check_quiet("R7 one short");
    act(2 * GS + 9, "R7 group2");
    idle(4);

    // R2: interleaved groups count apart
    for (int i = 0; i < THRESH; i++) begin
      act(1 * GS + i, "R2 group1");
      act(9 * GS + i, "R2 group9");
    end
    idle(4);

    // R8, R9: three hits without acknowledge; the third is dropped
    @(negedge clk); ack_en = 0; ref_ack = 0;
    for (int i = 0; i < THRESH; i++) act(4 * GS + i, "R9 first");
    for (int i = 0; i < THRESH; i++) act(6 * GS + i, "R9 second");
    for (int i = 0; i < THRESH; i++) act(7 * GS + i, "R9 dropped");
    idle(3);
    check(ref_req == 1, "R8 request held", ref_req, 1);
    check(int'(ref_first) == 4 * GS - 1, "R8 range held", int'(ref_first), 4 * GS - 1);
    check(exp_q.size() == 2, "R9 model depth", exp_q.size(), 2);
    @(negedge clk); ack_en = 1;
    idle(6);
    check_quiet("R9 drained after two");

    // R10: acknowledge with no request
    @(negedge clk); ack_en = 0; ref_ack = 1;
    @(negedge clk); ref_ack = 0; ack_en = 1;
    for (int i = 0; i < THRESH; i++) act(11 * GS + i, "R10 after idle ack");
    idle(6);

    check(exp_q.size() == 0, "R9 all expected seen", exp_q.size(), 0);
    check(ref_req == 0, "R8 final idle", ref_req, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule